// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives an SDRAM's clock-enable, command and address pins from reset until the memory is ready for normal use. It first keeps the device deselected for a configurable power-up delay, with chip select held high throughout. It then issues a fixed script of commands: a precharge of every bank, a parameterized number of auto-refresh commands (two by default), and a load of the mode register. A programmed number of idle NOP cycles separates each command from the next.

When the last wait after the mode-register load has elapsed, the block raises a ready flag. After that it leaves NOP on the bus, so a following controller can take over once it sees the flag. All delays are parameters in clock cycles. The defaults assume a 100 MHz clock: 10000 cycles of power-up delay, 4 after precharge, 8 after each refresh and 3 after the mode load. A test environment can shrink these counts.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While rst_n is low, the block drives the deselect word (command bus 111111), holds addr and ba at zero, holds init_done low and holds cke high.
- R2: For the first PWR_WAIT cycles after reset is released, only the deselect word appears on the command bus. The command bus is {cs_n, ras_n, cas_n, we_n, dqm[1], dqm[0]}.
- R3: After the power-up wait, the block issues exactly four commands in this order: precharge, auto-refresh, auto-refresh, mode-register load. Each is present for one cycle.
- R4: The command words are: deselect 111111, NOP 011111, precharge 001011, auto-refresh 000111, mode-register load 000011. No other word ever appears.
- R5: During the precharge cycle, addr[10] is 1 (all banks), every other addr bit is 0, and ba is 00.
- R6: Exactly T_RP NOP cycles separate the precharge from the first auto-refresh.
- R7: Exactly T_RFC NOP cycles follow each auto-refresh before the next command.
- R8: During the mode-register load cycle, addr equals MODE_WORD (default 0x027: full-page burst, sequential, CAS latency 2, burst length used for writes as well) and ba is 00.
- R9: init_done rises after exactly T_MRD NOP cycles following the mode-register load. It then stays high with NOP on the bus until the next reset.
- R10: cke is high in every cycle, in reset and out of it.
- R11: Asserting reset at any point, including during a command cycle or after init_done, aborts the script at once. On release, the full sequence restarts from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dqm | output | 2 | Byte masks, high while initializing |
| addr | output | ADDR_W | SDRAM address bus |
| ba | output | BA_W | SDRAM bank select |
| init_done | output | 1 | High once the sequence has completed |

## Verification
Two things can fall in the same cycle: a reset, and either the issue of a script command or the hold of the ready flag. The bench provokes this by dropping rst_n on the exact cycle the precharge is on the bus, and again after init_done has risen. It then checks two things. First, the bus returns to the deselect word and the ready flag drops at once. Second, after release, the whole power-up wait is counted again before the precharge reappears at its original cycle offset.

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq #(
  parameter int ADDR_W = 13,
  parameter int BA_W = 2,
  parameter int PWR_WAIT = 10000,
  parameter int T_RP = 4,
  parameter int T_RFC = 8,
  parameter int T_MRD = 3,
  parameter int N_REF = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = 'h027
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        dqm,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              init_done
);

  localparam int MAX_A = (PWR_WAIT > T_RFC) ? PWR_WAIT : T_RFC;
  localparam int MAX_B = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW = $clog2(MAX_W + 1);
  localparam int RW = $clog2(N_REF + 1);

  localparam logic [5:0] W_DESEL = 6'b111111;
  localparam logic [5:0] W_NOP   = 6'b011111;
  localparam logic [5:0] W_PRE   = 6'b001011;
  localparam logic [5:0] W_REF   = 6'b000111;
  localparam logic [5:0] W_LMR   = 6'b000011;

  typedef enum logic [2:0] {
    S_PWR, S_PRE, S_GAP_RP, S_REF, S_GAP_RFC, S_LMR, S_GAP_MRD, S_RDY
  } step_t;

  step_t          st, st_nx;
  logic [CW-1:0]  cnt;
  logic [RW-1:0]  refs;
  logic [CW-1:0]  lim;
  logic           gap_end;
  logic [5:0]     word;

  always_comb begin
    case (st)
      S_PWR:     lim = CW'(PWR_WAIT - 1);
      S_GAP_RP:  lim = CW'(T_RP - 1);
      S_GAP_RFC: lim = CW'(T_RFC - 1);
      S_GAP_MRD: lim = CW'(T_MRD - 1);
      default:   lim = '0;
    endcase
  end

  assign gap_end = (cnt == lim);

  always_comb begin
    st_nx = st;
    case (st)
      S_PWR:     if (gap_end) st_nx = S_PRE;
      S_PRE:     st_nx = S_GAP_RP;
      S_GAP_RP:  if (gap_end) st_nx = S_REF;
      S_REF:     st_nx = S_GAP_RFC;
      S_GAP_RFC: if (gap_end) st_nx = (refs == RW'(N_REF - 1)) ? S_LMR : S_REF;
      S_LMR:     st_nx = S_GAP_MRD;
      S_GAP_MRD: if (gap_end) st_nx = S_RDY;
      default:   st_nx = S_RDY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_PWR;
      cnt  <= '0;
      refs <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != st) cnt <= '0;
      else if (st == S_RDY) cnt <= '0;
      else cnt <= cnt + 1'b1;
      if (st == S_GAP_RFC && st_nx == S_REF) refs <= refs + 1'b1;
    end
  end

  always_comb begin
    case (st)
      S_PWR:   word = W_DESEL;
      S_PRE:   word = W_PRE;
      S_REF:   word = W_REF;
      S_LMR:   word = W_LMR;
      default: word = W_NOP;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n, dqm} = word;
  assign cke       = 1'b1;
  assign init_done = (st == S_RDY);
  assign ba        = '0;

  always_comb begin
    addr = '0;
    if (st == S_PRE) addr[10] = 1'b1;
    else if (st == S_LMR) addr = MODE_WORD;
  end

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = 'h027
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        dqm,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic              init_done
);
  logic [5:0] w;
  logic [ADDR_W-1:0] pre_addr;
  assign w = {cs_n, ras_n, cas_n, we_n, dqm};
  always_comb begin
    pre_addr = '0;
    pre_addr[10] = 1'b1;
  end

  AST_LEGAL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    w inside {6'b111111, 6'b011111, 6'b001011, 6'b000111, 6'b000011}); // R4
  AST_CKE_ON: assert property (@(posedge clk) disable iff (!rst_n) cke); // R10
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (w == 6'b001011) |-> (addr == pre_addr && ba == '0)); // R5
  AST_LMR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (w == 6'b000011) |-> (addr == MODE_WORD && ba == '0)); // R8
  AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (w == 6'b001011) |=> (w == 6'b011111)); // R6
  AST_REF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (w == 6'b000111) |=> (w == 6'b011111)); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (w == 6'b011111)); // R9
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .MODE_WORD(MODE_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .dqm(dqm), .addr(addr), .ba(ba),
  .init_done(init_done)
);

// File: tb/sdram_pwrup_seq_tb.sv
module sdram_pwrup_seq_tb;
  localparam int N = 20, TRP = 4, TRFC = 8, TMRD = 3;
  localparam logic [5:0] DESEL = 6'b111111, NOP = 6'b011111, PRE = 6'b001011,
                         REF = 6'b000111, LMR = 6'b000011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] dqm;
  logic [12:0] addr;
  logic [1:0] ba;
  int total = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sdram_pwrup_seq #(.PWR_WAIT(N), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .dqm(dqm), .addr(addr), .ba(ba),
    .init_done(init_done));

  localparam int NV = 12;
  localparam int V_CYC [NV] = '{0, 19, 20, 21, 24, 25, 33, 34, 42, 43, 46, 47};
  localparam logic [5:0] V_CMD [NV] = '{DESEL, DESEL, PRE, NOP, NOP, REF, NOP, REF, NOP, LMR, NOP, NOP};
  localparam logic [12:0] V_ADR [NV] = '{13'h0, 13'h0, 13'h400, 13'h0, 13'h0, 13'h0,
                                        13'h0, 13'h0, 13'h0, 13'h027, 13'h0, 13'h0};
  localparam logic V_DONE [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1};
  localparam string V_REQ [NV] = '{"R2", "R2", "R3", "R6", "R6", "R3", "R7", "R7",
                                   "R7", "R8", "R9", "R9"};

  function automatic logic [5:0] bus();
    return {cs_n, ras_n, cas_n, we_n, dqm};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int ncmd;
    int desel_bad;
    repeat (3) @(negedge clk);
    check("R1", {26'b0, bus()}, {26'b0, DESEL});
    check("R1", {18'b0, init_done, addr, ba}, 32'h0);
    check("R10", {31'b0, cke}, 32'h1);

    release_reset();
    for (int i = 0; i < NV; i++) begin
      while (cyc < V_CYC[i]) step();
      check(V_REQ[i], {26'b0, bus()}, {26'b0, V_CMD[i]});
      check(V_REQ[i], {17'b0, addr, ba}, {17'b0, V_ADR[i], 2'b00});
      check(V_REQ[i], {31'b0, init_done}, {31'b0, V_DONE[i]});
    end

    rst_n = 1'b0;
    #1;
    check("R11", {25'b0, init_done, bus()}, {25'b0, 1'b0, DESEL});
    check("R10", {31'b0, cke}, 32'h1);

    release_reset();
    ncmd = 0;
    desel_bad = 0;
    while (cyc < 60) begin
      if (cyc < N && bus() !== DESEL) desel_bad++;
      if (bus() !== DESEL && bus() !== NOP) ncmd++;
      if (cyc == 20) check("R5", {19'b0, addr}, 32'h400);
      step();
    end
    check("R2", desel_bad, 0);
    check("R3", ncmd, 4);
    check("R9", {31'b0, init_done}, 32'h1);
    check("R9", {26'b0, bus()}, {26'b0, NOP});

    rst_n = 1'b0;
    @(negedge clk);
    release_reset();
    while (cyc < 20) step();
    rst_n = 1'b0;
    #1;
    check("R11", {26'b0, bus()}, {26'b0, DESEL});
    release_reset();
    while (cyc < 19) step();
    check("R11", {26'b0, bus()}, {26'b0, DESEL});
    step();
    check("R11", {26'b0, bus()}, {26'b0, PRE});

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule